// File: doc/BRIEF.md
# Oscillator Waveform Selector

This block sits between a 24-bit phase accumulator and a 12-bit waveform DAC. For each accepted sample it forms four candidate waveforms from the accumulator and the noise register: sawtooth, triangle, pulse and noise. It then merges the ones that are selected into a single 12-bit output code. The triangle can fold on the MSB of a second voice (ring modulation). The pulse comes from a carry-only subtractor that compares the top twelve accumulator bits with a pulse width. A test input forces the pulse high.

A sample enters on a valid/ready handshake and leaves one cycle later from a registered output, also valid/ready. Back-pressure rules: the input is ready whenever the output register is empty or is being drained in the same cycle. While the output is valid and not taken, it holds its code and the input stalls. A build-time parameter selects a variant in which the sawtooth's top bit comes from a flip-flop. That flop holds bit 23 of the previously accepted sample.

Top module: `wavesel_top`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. A sample accepted on a clock edge appears on `out_code` with `out_valid` high right after that edge.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_code` does not change.
- R3: After reset, `out_valid` is 0, `out_code` is 0 and `in_ready` is 1.
- R4: Select encoding in `wave_sel`: bit 0 is triangle, bit 1 is sawtooth, bit 2 is pulse and bit 3 is noise. The sawtooth alone (`wave_sel`=0010) gives `acc[23:12]`.
- R5: With `ring_en`=0, the triangle alone (0001) gives `acc[22:11]` with every bit XORed with `acc[23]`.
- R6: With `ring_en`=1, the triangle fold bit is `acc[23] XOR NOT sync_msb`.
- R7: The pulse alone (0100) gives 0xFFF when `acc[23:12] >= pw` and 0x000 when `acc[23:12] < pw`.
- R8: With `test`=1, the pulse gives 0xFFF regardless of `acc` and `pw`.
- R9: The noise alone (1000) puts `lfsr` bits 20, 18, 14, 11, 9, 5, 2 and 0 on output bits 11 down to 4, in that order. Output bits 3..0 are 0.
- R10: Two or three selected waveforms without noise give the bitwise AND of their values. `wave_sel`=0000 gives 0.
- R11: Noise selected together with any other waveform gives 0.
- R12: With `SAW_MSB_REG`=1, the sawtooth's bit 11 is `acc[23]` of the previously accepted sample, and 0 for the first sample after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with in_valid |
| acc | input | 24 | Phase accumulator value |
| pw | input | 12 | Pulse width |
| wave_sel | input | 4 | Waveform select {noise, pulse, saw, tri} |
| test | input | 1 | Test bit, forces pulse high |
| sync_msb | input | 1 | MSB of the sync-source voice |
| ring_en | input | 1 | Ring-mode enable for the triangle fold |
| lfsr | input | 23 | Noise shift-register state |
| out_valid | output | 1 | Output code valid |
| out_ready | input | 1 | Downstream takes the output code |
| out_code | output | 12 | Waveform code for the DAC |

## Verification
The sawtooth and triangle are driven with accumulators whose MSB is set and clear, so a fold bit taken from the wrong place changes the result. Ring mode is tried with both levels of the sync MSB. The pulse comparator is probed at equality, one below, and the zero and full-scale ends, with and without `test`, to separate `>=` from `>`. Noise is driven with one tap set at a time and then all bits set, which exposes a swapped or shifted tap. Mixed selections, stalls against back-pressure and the registered-MSB variant are then run as directed cases.

// File: rtl/wave_pkg.sv
package wave_pkg;
  localparam int NOISE_TAPS = 8;
  // tap index feeding output bit (OUT_W-NOISE_TAPS+k)
  localparam int NOISE_TAP [NOISE_TAPS] = '{0, 2, 5, 9, 11, 14, 18, 20};

  typedef struct packed {
    logic noise;
    logic pulse;
    logic saw;
    logic tri_w;
  } wsel_t;
endpackage

// File: rtl/pulse_cmp.sv
module pulse_cmp #(
  parameter int W = 12
) (
  input  logic [W-1:0] phase,
  input  logic [W-1:0] width,
  input  logic         test,
  output logic         pulse
);
  logic [W:0] cy;
  assign cy[0] = 1'b1;

  generate
    for (genvar i = 0; i < W; i++) begin : g_chain
      logic b;
      assign b       = ~width[i];
      assign cy[i+1] = (phase[i] & b) | (cy[i] & (phase[i] ^ b));
    end
  endgenerate

  assign pulse = cy[W] | test;

  always_comb begin
    // R7
    carry_order_chk: assert (cy[W] == (phase >= width))
      else $error("carry chain disagrees with magnitude order");
    // R8
    test_force_chk: assert (!test || pulse)
      else $error("test did not force pulse");
  end
endmodule

// File: rtl/wave_sources.sv
module wave_sources
  import wave_pkg::*;
#(
  parameter int ACC_W  = 24,
  parameter int OUT_W  = 12,
  parameter int LFSR_W = 23
) (
  input  logic [ACC_W-1:0]  acc,
  input  logic              saw_msb,
  input  logic              sync_msb,
  input  logic              ring_en,
  input  logic [LFSR_W-1:0] lfsr,
  output logic [OUT_W-1:0]  saw,
  output logic [OUT_W-1:0]  tri_v,
  output logic [OUT_W-1:0]  noise
);
  localparam int LOW_BITS = OUT_W - NOISE_TAPS;

  logic fold;

  assign saw  = {saw_msb, acc[ACC_W-2 -: OUT_W-1]};
  assign fold = ring_en ? (acc[ACC_W-1] ^ ~sync_msb) : acc[ACC_W-1];
  assign tri_v = acc[ACC_W-2 -: OUT_W] ^ {OUT_W{fold}};

  generate
    for (genvar k = 0; k < NOISE_TAPS; k++) begin : g_tap
      assign noise[LOW_BITS+k] = lfsr[NOISE_TAP[k]];
    end
    if (LOW_BITS > 0) begin : g_low
      assign noise[LOW_BITS-1:0] = '0;
    end
  endgenerate

  always_comb begin
    // R5
    tri_flat_chk: assert (ring_en || (tri_v[OUT_W-1] == (acc[ACC_W-2] ^ acc[ACC_W-1])))
      else $error("triangle top bit not folded by own MSB");
  end
endmodule

// File: rtl/wave_combine.sv
module wave_combine
  import wave_pkg::*;
#(
  parameter int OUT_W = 12
) (
  input  wsel_t            sel,
  input  logic [OUT_W-1:0] saw,
  input  logic [OUT_W-1:0] tri_v,
  input  logic             pulse,
  input  logic [OUT_W-1:0] noise,
  output logic [OUT_W-1:0] code
);
  localparam int NSRC = 4;

  logic [NSRC-1:0]             en;
  logic [NSRC-1:0][OUT_W-1:0]  src;
  logic [NSRC:0][OUT_W-1:0]    acc_and;
  logic                        noise_mix;

  assign en  = {sel.noise, sel.pulse, sel.saw, sel.tri_w};
  assign src = {noise, {OUT_W{pulse}}, saw, tri_v};
  assign acc_and[0] = '1;

  generate
    for (genvar s = 0; s < NSRC; s++) begin : g_and
      assign acc_and[s+1] = en[s] ? (acc_and[s] & src[s]) : acc_and[s];
    end
  endgenerate

  assign noise_mix = sel.noise && (sel.pulse || sel.saw || sel.tri_w);

  always_comb begin
    if (en == '0 || noise_mix) code = '0;
    else                       code = acc_and[NSRC];
  end

  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      // R10
      code_subset_chk: assert (!en[s] || ((code & ~src[s]) == '0))
        else $error("output bit set that a selected source lacks");
    end
  end
endmodule

// File: rtl/wavesel_top.sv
module wavesel_top
  import wave_pkg::*;
#(
  parameter int ACC_W       = 24,
  parameter int OUT_W       = 12,
  parameter int LFSR_W      = 23,
  parameter bit SAW_MSB_REG = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ACC_W-1:0]  acc,
  input  logic [OUT_W-1:0]  pw,
  input  logic [3:0]        wave_sel,
  input  logic              test,
  input  logic              sync_msb,
  input  logic              ring_en,
  input  logic [LFSR_W-1:0] lfsr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OUT_W-1:0]  out_code
);
  logic             take;
  logic             saw_msb;
  logic             pulse;
  logic [OUT_W-1:0] saw, tri_v, noise, code;
  wsel_t            sel;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign sel      = wave_sel;

  generate
    if (SAW_MSB_REG) begin : g_msb_ff
      logic msb_q;
      always_ff @(posedge clk) begin
        if (!rst_n)    msb_q <= 1'b0;
        else if (take) msb_q <= acc[ACC_W-1];
      end
      assign saw_msb = msb_q;
    end else begin : g_msb_direct
      assign saw_msb = acc[ACC_W-1];
    end
  endgenerate

  pulse_cmp #(.W(OUT_W)) u_pulse (
    .phase (acc[ACC_W-1 -: OUT_W]),
    .width (pw),
    .test  (test),
    .pulse (pulse)
  );

  wave_sources #(.ACC_W(ACC_W), .OUT_W(OUT_W), .LFSR_W(LFSR_W)) u_src (
    .acc      (acc),
    .saw_msb  (saw_msb),
    .sync_msb (sync_msb),
    .ring_en  (ring_en),
    .lfsr     (lfsr),
    .saw      (saw),
    .tri_v    (tri_v),
    .noise    (noise)
  );

  wave_combine #(.OUT_W(OUT_W)) u_mix (
    .sel   (sel),
    .saw   (saw),
    .tri_v (tri_v),
    .pulse (pulse),
    .noise (noise),
    .code  (code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_code  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_code  <= code;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R1
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);
  // R2
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code)));
  // R11
  noise_mix_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && wave_sel[3] && (wave_sel[2:0] != 3'b000)) |=> (out_code == '0));
  // R8
  test_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && wave_sel == 4'b0100 && test) |=> (out_code == '1));
endmodule

// File: tb/wavesel_top_tb.sv
module wavesel_top_tb;
  typedef struct packed {
    logic [23:0] acc;
    logic [11:0] pw;
    logic [3:0]  sel;
    logic        test;
    logic        sync;
    logic        ring;
    logic [22:0] lfsr;
    logic [11:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{24'hABC123, 12'h000, 4'b0010, 1'b0, 1'b0, 1'b0, 23'h0, 12'hABC, 8'd4},  // R4
    '{24'h2AB800, 12'h000, 4'b0001, 1'b0, 1'b0, 1'b0, 23'h0, 12'h557, 8'd5},  // R5
    '{24'hAAB800, 12'h000, 4'b0001, 1'b0, 1'b0, 1'b0, 23'h0, 12'hAA8, 8'd5},  // R5
    '{24'h2AB800, 12'h000, 4'b0001, 1'b0, 1'b0, 1'b1, 23'h0, 12'hAA8, 8'd6},  // R6
    '{24'h2AB800, 12'h000, 4'b0001, 1'b0, 1'b1, 1'b1, 23'h0, 12'h557, 8'd6},  // R6
    '{24'hAAB800, 12'h000, 4'b0001, 1'b0, 1'b1, 1'b1, 23'h0, 12'hAA8, 8'd6},  // R6
    '{24'h800000, 12'h800, 4'b0100, 1'b0, 1'b0, 1'b0, 23'h0, 12'hFFF, 8'd7},  // R7
    '{24'h7FF000, 12'h800, 4'b0100, 1'b0, 1'b0, 1'b0, 23'h0, 12'h000, 8'd7},  // R7
    '{24'h000000, 12'h000, 4'b0100, 1'b0, 1'b0, 1'b0, 23'h0, 12'hFFF, 8'd7},  // R7
    '{24'hFFF000, 12'hFFF, 4'b0100, 1'b0, 1'b0, 1'b0, 23'h0, 12'hFFF, 8'd7},  // R7
    '{24'hFFEFFF, 12'hFFF, 4'b0100, 1'b0, 1'b0, 1'b0, 23'h0, 12'h000, 8'd7},  // R7
    '{24'h000000, 12'h001, 4'b0100, 1'b1, 1'b0, 1'b0, 23'h0, 12'hFFF, 8'd8},  // R8
    '{24'h7FF000, 12'hFFF, 4'b0100, 1'b1, 1'b0, 1'b0, 23'h0, 12'hFFF, 8'd8},  // R8
    '{24'h000000, 12'h000, 4'b1000, 1'b0, 1'b0, 1'b0, 23'h100000, 12'h800, 8'd9}, // R9
    '{24'h000000, 12'h000, 4'b1000, 1'b0, 1'b0, 1'b0, 23'h000001, 12'h010, 8'd9}, // R9
    '{24'h000000, 12'h000, 4'b1000, 1'b0, 1'b0, 1'b0, 23'h000800, 12'h100, 8'd9}, // R9
    '{24'h000000, 12'h000, 4'b1000, 1'b0, 1'b0, 1'b0, 23'h000004, 12'h020, 8'd9}, // R9
    '{24'h000000, 12'h000, 4'b1000, 1'b0, 1'b0, 1'b0, 23'h7FFFFF, 12'hFF0, 8'd9}, // R9
    '{24'hABC000, 12'h100, 4'b0110, 1'b0, 1'b0, 1'b0, 23'h0, 12'hABC, 8'd10}, // R10
    '{24'hABC000, 12'hFFF, 4'b0110, 1'b0, 1'b0, 1'b0, 23'h0, 12'h000, 8'd10}, // R10
    '{24'h800000, 12'h000, 4'b0011, 1'b0, 1'b0, 1'b0, 23'h0, 12'h800, 8'd10}, // R10
    '{24'hFFFFFF, 12'h000, 4'b0000, 1'b0, 1'b0, 1'b0, 23'h7FFFFF, 12'h000, 8'd10}, // R10
    '{24'hFFFFFF, 12'h000, 4'b1010, 1'b0, 1'b0, 1'b0, 23'h7FFFFF, 12'h000, 8'd11}, // R11
    '{24'hFFFFFF, 12'h000, 4'b1100, 1'b1, 1'b0, 1'b0, 23'h7FFFFF, 12'h000, 8'd11}  // R11
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready, in_ready_d;
  logic [23:0] acc = '0;
  logic [11:0] pw = '0;
  logic [3:0]  wave_sel = '0;
  logic        test = 1'b0, sync_msb = 1'b0, ring_en = 1'b0;
  logic [22:0] lfsr = '0;
  logic        out_valid, out_valid_d;
  logic        out_ready = 1'b1;
  logic [11:0] out_code, out_code_d;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wavesel_top u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .acc(acc), .pw(pw), .wave_sel(wave_sel), .test(test), .sync_msb(sync_msb),
    .ring_en(ring_en), .lfsr(lfsr), .out_valid(out_valid), .out_ready(out_ready),
    .out_code(out_code)
  );

  wavesel_top #(.SAW_MSB_REG(1'b1)) u_dut_dly (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_d),
    .acc(acc), .pw(pw), .wave_sel(wave_sel), .test(test), .sync_msb(sync_msb),
    .ring_en(ring_en), .lfsr(lfsr), .out_valid(out_valid_d), .out_ready(out_ready),
    .out_code(out_code_d)
  );

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    acc = v.acc; pw = v.pw; wave_sel = v.sel; test = v.test;
    sync_msb = v.sync; ring_en = v.ring; lfsr = v.lfsr;
  endtask

  // drive at negedge, accept on posedge, sample at next negedge
  task automatic send(input vec_t v);
    drive(v);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (R1..) actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    // R3: reset state
    check("R3 out_valid", {11'b0, out_valid}, 12'h000);
    check("R3 out_code", out_code, 12'h000);
    check("R3 in_ready", {11'b0, in_ready}, 12'h001);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      send(VECS[i]);
      checks++;
      if (out_valid !== 1'b1 || out_code !== VECS[i].exp) begin
        errors++;
        $display("FAIL R%0d vec %0d actual=%h/%b expected=%h/1",
                 VECS[i].req, i, out_code, out_valid, VECS[i].exp);
      end
    end
    // R1: output drained with out_ready high and no new input
    @(negedge clk);
    check("R1 drain", {11'b0, out_valid}, 12'h000);

    // R2 / R1: back-pressure
    out_ready = 1'b0;
    v = VECS[0];
    send(v);
    check("R1 stall valid", {11'b0, out_valid}, 12'h001);
    check("R1 in_ready low", {11'b0, in_ready}, 12'h000);
    drive(VECS[1]);
    in_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R2 hold code", out_code, 12'hABC);
      check("R2 hold valid", {11'b0, out_valid}, 12'h001);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 next accepted", out_code, 12'h557);
    check("R1 next valid", {11'b0, out_valid}, 12'h001);
    @(negedge clk);

    // R12: registered sawtooth MSB variant, fresh reset
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    v = VECS[0]; v.sel = 4'b0010; v.acc = 24'hFFF000;
    send(v);
    check("R12 first after reset", out_code_d, 12'h7FF);
    check("R4 direct msb", out_code, 12'hFFF);
    v.acc = 24'h000000;
    send(v);
    check("R12 prev msb one", out_code_d, 12'h800);
    send(v);
    check("R12 prev msb zero", out_code_d, 12'h000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule